// File: doc/BRIEF.md
# PCI Target Exclusive-Access Lock Monitor

This block sits next to the address decoder of a simplified PCI target. It follows the bus-wide LOCK# signal and records whether one initiator has claimed exclusive use of the target. It also drives the target's response pins for a data phase that has a fixed wait-state count. An initiator claims the target by addressing it with LOCK# high and then pulling LOCK# low on the next clock. From then on, the target serves only accesses that begin with LOCK# high in the address clock. Any other initiator reaches a locked target with LOCK# already low, and the target turns that access away with a retry. The lock ends when the owner lets LOCK# go high in the clock that follows the final data transfer of one of its transactions.

Every control pin is active low and is sampled on the rising clock edge. The decode-hit input is only looked at in the address clock, which is the first clock with FRAME# low while the target is idle. A transaction that misses the decoder is followed until the bus goes idle. Such a transaction does not move the lock and does not drive any target pin. The number of wait states between DEVSEL# and TRDY# is set by a parameter. A second parameter removes the lock logic altogether.

Top module: `pci_lock_target`

## Requirements
- R1: While the synchronous active-low reset is applied and in the clock after it, `locked` and `retry_req` are 0 and DEVSEL#, TRDY# and STOP# are high.
- R2: An unlocked target that hits in an address clock with LOCK# high, and that then samples LOCK# low in the next clock, shows `locked` = 1 from the clock after that second sample.
- R3: If LOCK# is still high in the clock after such an address clock, the target stays unlocked and the access completes normally.
- R4: An unlocked target that sees LOCK# already low in its address clock ignores LOCK#. It serves the access with normal DEVSEL#/TRDY# and stays unlocked.
- R5: A locked target that hits with LOCK# low in the address clock drives DEVSEL# and STOP# low and sets `retry_req` = 1 from the next clock. It keeps TRDY# high and transfers no data. It holds this until it samples FRAME# high, and it releases DEVSEL#, STOP# and `retry_req` in the clock that follows.
- R6: An access that is served (unlocked, or locked with LOCK# high in the address clock) drives DEVSEL# low the clock after the address clock. It drives TRDY# low WAIT_STATES clocks later (1 by default).
- R7: A locked target unlocks when the clock right after the last data transfer samples LOCK# high. The last transfer is a clock with IRDY# low, TRDY# low and FRAME# high. `locked` reads 0 from the clock after that sample.
- R8: If the owner keeps LOCK# low through the clock after its last transfer, the target stays locked.
- R9: A transaction whose address clock has the decode hit at 0 never drives DEVSEL#, TRDY# or STOP# low, and it never sets the lock. This holds even when the LOCK# pattern would otherwise claim the target.
- R10: In a burst, TRDY# stays low while FRAME# is low. DEVSEL# and TRDY# go high in the clock after the last transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frame_n | input | 1 | FRAME# from the initiator |
| lock_n | input | 1 | Bus LOCK# |
| irdy_n | input | 1 | IRDY# from the initiator |
| hit | input | 1 | Address decoder match, used in the address clock |
| devsel_n | output | 1 | DEVSEL# drive (low = asserted) |
| trdy_n | output | 1 | TRDY# drive (low = asserted) |
| stop_n | output | 1 | STOP# drive (low = asserted) |
| locked | output | 1 | Target is held by an owner |
| retry_req | output | 1 | Retry termination in progress |

## Verification
The bench targets the one-clock windows that the lock depends on. It checks that LOCK# is sampled exactly one clock after the address for a claim, and exactly one clock after the last transfer for a release. A design that is off by one clock would either lock on a claim where LOCK# dropped late, or stay locked after the owner let go. Other checks send non-owner accesses that keep FRAME# low for several clocks; a design that released STOP# early, or asserted TRDY#, would hand data to the wrong initiator. Misses that carry a LOCK# claim pattern, and owner transactions that keep LOCK# low at the end, catch a design that changes the lock on foreign traffic or releases it when it should not.

// File: rtl/pci_lock_pkg.sv
package pci_lock_pkg;

   // Target bus phase; outputs are decoded from the registered phase
   typedef enum logic [2:0] {
      PH_IDLE  = 3'd0,
      PH_BUSY  = 3'd1,   // foreign transaction in flight
      PH_WAIT  = 3'd2,   // DEVSEL# low, TRDY# held off
      PH_DATA  = 3'd3,   // DEVSEL# and TRDY# low
      PH_RETRY = 3'd4    // DEVSEL# and STOP# low
   } tgt_phase_e;

   localparam int unsigned MAX_WAIT_STATES = 7;

endpackage

// File: rtl/pci_lock_track.sv
module pci_lock_track #(
   parameter bit LOCK_ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lock_n,
   input  logic addr_clk,
   input  logic hit,
   input  logic last_xfer,
   output logic locked,
   output logic deny
);

   generate
      if (LOCK_ENABLE) begin : g_lock
         logic claim_q;   // address clock seen with LOCK# high on an unlocked target
         logic rel_q;     // clock after the final transfer
         logic held_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               claim_q <= 1'b0;
               rel_q   <= 1'b0;
               held_q  <= 1'b0;
            end else begin
               claim_q <= addr_clk && hit && !held_q && lock_n;
               rel_q   <= last_xfer;
               if (claim_q && !lock_n)
                  held_q <= 1'b1;
               else if (rel_q && lock_n)
                  held_q <= 1'b0;
            end
         end

         assign locked = held_q;
         assign deny   = held_q && !lock_n;
      end else begin : g_nolock
         assign locked = 1'b0;
         assign deny   = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/pci_lock_seq.sv
module pci_lock_seq
   import pci_lock_pkg::*;
#(
   parameter int unsigned WAIT_STATES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_n,
   input  logic irdy_n,
   input  logic hit,
   input  logic deny,
   output logic addr_clk,
   output logic last_xfer,
   output logic devsel_n,
   output logic trdy_n,
   output logic stop_n,
   output logic retry_req
);

   localparam int unsigned CW = (WAIT_STATES > 1) ? $clog2(WAIT_STATES) : 1;
   localparam tgt_phase_e  FIRST_PH = (WAIT_STATES == 0) ? PH_DATA : PH_WAIT;

   tgt_phase_e ph_q, ph_d;
   logic       wait_done;

   assign addr_clk  = (ph_q == PH_IDLE) && !frame_n;
   assign last_xfer = (ph_q == PH_DATA) && !irdy_n && frame_n;

   generate
      if (WAIT_STATES == 0) begin : g_nowait
         assign wait_done = 1'b1;
      end else begin : g_wait
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (addr_clk)
               cnt_q <= CW'(WAIT_STATES - 1);
            else if (ph_q == PH_WAIT && cnt_q != '0)
               cnt_q <= cnt_q - CW'(1);
         end
         assign wait_done = (cnt_q == '0);
      end
   endgenerate

   always_comb begin
      ph_d = ph_q;
      case (ph_q)
         PH_IDLE: begin
            if (!frame_n) begin
               if (!hit)      ph_d = PH_BUSY;
               else if (deny) ph_d = PH_RETRY;
               else           ph_d = FIRST_PH;
            end
         end
         PH_BUSY:  if (frame_n && irdy_n) ph_d = PH_IDLE;
         PH_WAIT:  if (wait_done)         ph_d = PH_DATA;
         PH_DATA:  if (last_xfer)         ph_d = PH_IDLE;
         PH_RETRY: if (frame_n)           ph_d = PH_IDLE;
         default:                         ph_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) ph_q <= PH_IDLE;
      else        ph_q <= ph_d;
   end

   assign devsel_n  = !((ph_q == PH_WAIT) || (ph_q == PH_DATA) || (ph_q == PH_RETRY));
   assign trdy_n    = (ph_q != PH_DATA);
   assign stop_n    = (ph_q != PH_RETRY);
   assign retry_req = (ph_q == PH_RETRY);

endmodule

// File: rtl/pci_lock_target.sv
module pci_lock_target
   import pci_lock_pkg::*;
#(
   parameter int unsigned WAIT_STATES = 1,
   parameter bit          LOCK_ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_n,
   input  logic lock_n,
   input  logic irdy_n,
   input  logic hit,
   output logic devsel_n,
   output logic trdy_n,
   output logic stop_n,
   output logic locked,
   output logic retry_req
);

   generate
      if (WAIT_STATES > MAX_WAIT_STATES) begin : g_bad_wait
         $error("pci_lock_target: WAIT_STATES above supported limit");
      end
   endgenerate

   logic addr_clk;
   logic last_xfer;
   logic deny;

   pci_lock_track #(
      .LOCK_ENABLE (LOCK_ENABLE)
   ) track_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .lock_n    (lock_n),
      .addr_clk  (addr_clk),
      .hit       (hit),
      .last_xfer (last_xfer),
      .locked    (locked),
      .deny      (deny)
   );

   pci_lock_seq #(
      .WAIT_STATES (WAIT_STATES)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_n   (frame_n),
      .irdy_n    (irdy_n),
      .hit       (hit),
      .deny      (deny),
      .addr_clk  (addr_clk),
      .last_xfer (last_xfer),
      .devsel_n  (devsel_n),
      .trdy_n    (trdy_n),
      .stop_n    (stop_n),
      .retry_req (retry_req)
   );

endmodule

// File: rtl/pci_lock_target_chk.sv
module pci_lock_target_chk (
   input logic clk,
   input logic rst_n,
   input logic frame_n,
   input logic lock_n,
   input logic hit,
   input logic devsel_n,
   input logic trdy_n,
   input logic stop_n,
   input logic locked,
   input logic retry_req,
   input logic addr_clk,
   input logic last_xfer
);

   assert_reset_quiet_R1: assert property (@(posedge clk)
      !rst_n |=> (devsel_n && trdy_n && stop_n && !locked && !retry_req));

   assert_lock_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked) |-> $past(!lock_n));

   assert_retry_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_n |-> (trdy_n && !devsel_n && retry_req));

   assert_retry_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_n && frame_n) |=> (stop_n && devsel_n && !retry_req));

   assert_trdy_with_devsel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n |-> !devsel_n);

   assert_unlock_on_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(locked) |-> $past(lock_n));

   assert_miss_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_clk && !hit) |=> (devsel_n && trdy_n && stop_n && !$rose(locked)));

   assert_release_after_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
      last_xfer |=> (devsel_n && trdy_n));

endmodule

bind pci_lock_target pci_lock_target_chk chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .frame_n   (frame_n),
   .lock_n    (lock_n),
   .hit       (hit),
   .devsel_n  (devsel_n),
   .trdy_n    (trdy_n),
   .stop_n    (stop_n),
   .locked    (locked),
   .retry_req (retry_req),
   .addr_clk  (addr_clk),
   .last_xfer (last_xfer)
);

// File: tb/pci_lock_target_tb_top.sv
module pci_lock_target_tb_top;

   localparam int WAIT_STATES = 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic frame_n = 1'b1, lock_n = 1'b1, irdy_n = 1'b1, hit = 1'b0;
   logic devsel_n, trdy_n, stop_n, locked, retry_req;

   int compared = 0;
   int mismatched = 0;
   int cycles = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;   // 250 MHz

   pci_lock_target #(.WAIT_STATES(WAIT_STATES), .LOCK_ENABLE(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .lock_n(lock_n),
      .irdy_n(irdy_n), .hit(hit), .devsel_n(devsel_n), .trdy_n(trdy_n),
      .stop_n(stop_n), .locked(locked), .retry_req(retry_req));

   // Behavioural reference: phase 0 idle, 1 foreign, 2 waiting, 3 data, 4 retry
   int m_ph = 0, m_wait = 0;
   bit m_locked = 0, m_claim = 0, m_rel = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_wait = 0; m_locked = 0; m_claim = 0; m_rel = 0;
      end else begin
         bit start, fin;
         int nph;
         start = (m_ph == 0) && !frame_n;
         fin   = (m_ph == 3) && !irdy_n && frame_n;
         if (m_claim && !lock_n) m_locked = 1;
         else if (m_rel && lock_n) m_locked = 0;
         m_claim = start && hit && lock_n && !m_locked;
         m_rel   = fin;
         nph = m_ph;
         if (m_ph == 0 && start) begin
            if (!hit) nph = 1;
            else if (m_locked_before(lock_n)) nph = 4;
            else begin m_wait = WAIT_STATES; nph = (m_wait == 0) ? 3 : 2; end
         end else if (m_ph == 1 && frame_n && irdy_n) nph = 0;
         else if (m_ph == 2) begin m_wait--; if (m_wait <= 0) nph = 3; end
         else if (m_ph == 3 && fin) nph = 0;
         else if (m_ph == 4 && frame_n) nph = 0;
         m_ph = nph;
      end
   end

   // Owner test uses the lock state from before this edge
   bit locked_prev = 0;
   always @(negedge clk) locked_prev = m_locked;
   function automatic bit m_locked_before(input logic ln);
      return locked_prev && !ln;
   endfunction

   task automatic check(input string req, input string what, input logic act, input logic exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   task automatic compare_all();
      check(cur_req, "devsel_n",  devsel_n,  !(m_ph == 2 || m_ph == 3 || m_ph == 4));
      check(cur_req, "trdy_n",    trdy_n,    m_ph != 3);
      check(cur_req, "stop_n",    stop_n,    m_ph != 4);
      check(cur_req, "retry_req", retry_req, m_ph == 4);
      check(cur_req, "locked",    locked,    m_locked);
   endtask

   task automatic step(input logic f, input logic l, input logic i, input logic h);
      frame_n = f; lock_n = l; irdy_n = i; hit = h;
      @(negedge clk);
      compare_all();
   endtask

   // One transaction: lock in address clock, lock during body, lock after end
   task automatic txn(input logic h, input logic la, input logic l2, input logic lend, input int nph);
      step(1'b0, la, 1'b1, h);
      if (!h) begin
         step(1'b0, l2, 1'b0, 1'b0);
         step(1'b1, l2, 1'b0, 1'b0);
      end else begin
         int p;
         bit done;
         p = 0; done = 0;
         for (int g = 0; g < 32 && !done; g++) begin
            if (!stop_n) begin
               step(1'b1, l2, 1'b0, 1'b0);
               done = 1;
            end else begin
               logic t;
               t = trdy_n;
               step((p == nph - 1) ? 1'b1 : 1'b0, l2, 1'b0, 1'b0);
               if (!t) begin p++; if (p == nph) done = 1; end
            end
         end
      end
      step(1'b1, lend, 1'b1, 1'b0);
      step(1'b1, lend, 1'b1, 1'b0);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         mismatched++;
         $display("FAIL watchdog: actual hung run, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      cur_req = "R1";
      repeat (3) @(negedge clk);
      compare_all();
      check("R1", "locked in reset", locked, 1'b0);
      rst_n = 1'b1;
      step(1'b1, 1'b1, 1'b1, 1'b0);
      check("R1", "stop_n after reset", stop_n, 1'b1);

      cur_req = "R6";                       // plain access, timing of DEVSEL#/TRDY#
      step(1'b0, 1'b1, 1'b1, 1'b1);
      check("R6", "devsel_n after address", devsel_n, 1'b0);
      check("R6", "trdy_n wait state", trdy_n, 1'b1);
      step(1'b1, 1'b1, 1'b0, 1'b0);
      check("R6", "trdy_n data", trdy_n, 1'b0);
      step(1'b1, 1'b1, 1'b0, 1'b0);
      step(1'b1, 1'b1, 1'b1, 1'b0);

      cur_req = "R3";
      txn(1'b1, 1'b1, 1'b1, 1'b1, 1);
      check("R3", "no lock without LOCK# drop", locked, 1'b0);

      cur_req = "R4";
      txn(1'b1, 1'b0, 1'b0, 1'b0, 1);
      check("R4", "LOCK# low at address ignored", locked, 1'b0);

      cur_req = "R2";
      txn(1'b1, 1'b1, 1'b0, 1'b0, 1);
      check("R2", "lock claimed", locked, 1'b1);

      cur_req = "R5";
      step(1'b0, 1'b0, 1'b1, 1'b1);
      check("R5", "stop_n on non-owner", stop_n, 1'b0);
      check("R5", "trdy_n held", trdy_n, 1'b1);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      check("R5", "stop_n held while FRAME# low", stop_n, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      check("R5", "stop_n released", stop_n, 1'b1);
      check("R5", "devsel_n released", devsel_n, 1'b1);
      step(1'b1, 1'b0, 1'b1, 1'b0);
      check("R5", "still locked after retry", locked, 1'b1);

      cur_req = "R9";
      txn(1'b0, 1'b1, 1'b1, 1'b1, 1);
      check("R9", "miss keeps lock", locked, 1'b1);

      cur_req = "R8";
      txn(1'b1, 1'b1, 1'b0, 1'b0, 1);
      check("R8", "owner keeps lock", locked, 1'b1);

      cur_req = "R10";
      txn(1'b1, 1'b1, 1'b0, 1'b1, 3);
      check("R7", "owner released lock", locked, 1'b0);
      check("R10", "devsel_n after burst", devsel_n, 1'b1);

      cur_req = "R9";
      txn(1'b0, 1'b1, 1'b0, 1'b0, 1);
      check("R9", "miss does not claim", locked, 1'b0);

      cur_req = "R7";
      txn(1'b1, 1'b1, 1'b0, 1'b0, 1);
      check("R2", "reclaimed", locked, 1'b1);
      txn(1'b1, 1'b0, 1'b0, 1'b0, 1);
      check("R5", "second non-owner retried, lock kept", locked, 1'b1);
      txn(1'b1, 1'b1, 1'b1, 1'b1, 2);
      check("R7", "unlock after owner burst", locked, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule